// File: doc/BRIEF.md
# Interrupt Line Claim Tracker

This block follows the service state of a bank of level-sensitive interrupt lines. Each line is in one of three states: quiet, waiting for a handler, or owned by a handler. When a line is first seen asserted while quiet, it becomes waiting. At that moment the block raises a one-cycle request pulse for that line, and the downstream logic turns the pulse into an interrupt message.

Software reaches the block through one register that is as wide as the line bank. It has three access kinds:

- A **read** returns the mask of waiting lines and changes nothing.
- A **swap** writes a claim mask. In the same cycle it returns, bit by bit, which of those claims succeeded. Only one of several competing handlers can win a given line.
- A **store** writes a release mask. It hands owned lines back to the quiet state.

A line whose input is still asserted when it is released starts a new round on the following cycle.

Top module: `intr_claim_tracker`

## Requirements
- R1: During and directly after synchronous reset, every line is quiet, `irq_pulse` is all zero, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: Each line input passes through two synchronizing flops before it is sampled. An input that rises ahead of clock edge k moves a quiet line to waiting at edge k+2.
- R3: When a line moves from quiet to waiting, its bit of `irq_pulse` is high for exactly one cycle. No pulse occurs otherwise.
- R4: A swap returns `bus_rdata` bit i = 1, one cycle later with `bus_rvalid` = 1, exactly when `bus_wdata` bit i was 1 and line i was waiting before that edge. Each such line becomes owned. The result uses the state before the update, so a line that only becomes waiting at the swap's edge returns 0 and stays waiting.
- R5: A store with `bus_wdata` bit i = 1 returns owned line i to quiet. One store may release any number of lines.
- R6: A read returns a 1 in `bus_rdata`, one cycle later with `bus_rvalid` = 1, for each waiting line. It changes no line state.
- R7: A swap bit for a line that is not waiting has no effect. A store bit for a line that is not owned has no effect.
- R8: If a released line's input is still asserted, the line becomes waiting again at the next edge and emits a new pulse.
- R9: If more than one access kind is asserted in a cycle, swap wins over store and store wins over read. Only the winning access acts. In a cycle with neither read nor swap, `bus_rdata` is 0 and `bus_rvalid` is 0.
- R10: A waiting line stays waiting after its input drops. The input is only sampled while the line is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Asynchronous level interrupt inputs |
| bus_rd | input | 1 | Read access strobe |
| bus_wr | input | 1 | Store (release) access strobe |
| bus_swap | input | 1 | Swap (claim) access strobe |
| bus_wdata | input | NUM_LINES | Claim or release mask |
| bus_rdata | output | NUM_LINES | Registered read or swap result |
| bus_rvalid | output | 1 | High in the cycle `bus_rdata` carries a result |
| irq_pulse | output | NUM_LINES | One-cycle request pulse per newly waiting line |

## Verification
The hard cases are a swap that arrives at the very edge where a line first turns waiting, and a release at the edge after which a still-high input re-arms the line. The bench provokes the first directly. It raises a line and times a swap so that the swap's edge is the line's quiet-to-waiting edge. It then expects a zero claim bit together with the request pulse, and a later read showing the line waiting. The random phase makes claims, releases and new assertions coincide often, and a bench-side reference model judges every cycle's pulse and result.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_PEND  = 2'd1,
    LN_TAKEN = 2'd2
  } line_state_e;
endpackage

// File: rtl/icl_sync.sv
module icl_sync #(
  parameter int WIDTH  = 28,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/icl_line.sv
module icl_line
  import icl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sampled,
  input  logic claim,
  input  logic release_i,
  output logic is_pend,
  output logic is_taken,
  output logic won,
  output logic pulse
);
  line_state_e state_q;

  assign is_pend  = (state_q == LN_PEND);
  assign is_taken = (state_q == LN_TAKEN);
  assign won      = claim && is_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LN_IDLE;
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      unique case (state_q)
        LN_IDLE: begin
          if (sampled) begin
            state_q <= LN_PEND;
            pulse   <= 1'b1;
          end
        end
        LN_PEND: begin
          if (claim) state_q <= LN_TAKEN;
        end
        LN_TAKEN: begin
          if (release_i) state_q <= LN_IDLE;
        end
        default: state_q <= LN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_claim_tracker.sv
module intr_claim_tracker #(
  parameter int NUM_LINES   = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic                 bus_swap,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_LINES-1:0] irq_pulse
);
  logic [NUM_LINES-1:0] sampled;
  logic [NUM_LINES-1:0] pend_mask;
  logic [NUM_LINES-1:0] taken_mask;
  logic [NUM_LINES-1:0] win_mask;
  logic                 do_swap, do_store, do_read;

  // swap outranks store, store outranks read
  assign do_swap  = bus_swap;
  assign do_store = bus_wr && !bus_swap;
  assign do_read  = bus_rd && !bus_swap && !bus_wr;

  icl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (sampled)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    icl_line u_line (
      .clk       (clk),
      .rst       (rst),
      .sampled   (sampled[i]),
      .claim     (do_swap && bus_wdata[i]),
      .release_i (do_store && bus_wdata[i]),
      .is_pend   (pend_mask[i]),
      .is_taken  (taken_mask[i]),
      .won       (win_mask[i]),
      .pulse     (irq_pulse[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= do_swap || do_read;
      if (do_swap)      bus_rdata <= win_mask;
      else if (do_read) bus_rdata <= pend_mask;
      else              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/intr_claim_tracker_chk.sv
module intr_claim_tracker_chk #(
  parameter int NUM_LINES   = 28,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic                 bus_swap,
  input logic [NUM_LINES-1:0] bus_wdata,
  input logic [NUM_LINES-1:0] bus_rdata,
  input logic                 bus_rvalid,
  input logic [NUM_LINES-1:0] irq_pulse,
  input logic [NUM_LINES-1:0] pend_mask,
  input logic [NUM_LINES-1:0] taken_mask
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_pulse == '0 && bus_rdata == '0 && !bus_rvalid));

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse & ~$past(irq_in, SYNC_STAGES + 1)) == '0);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse & $past(irq_pulse)) == '0);

  // R4
  claim_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_swap)) |-> (bus_rdata & ~$past(bus_wdata)) == '0);

  // R9
  result_source_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> ($past(bus_swap) || $past(bus_rd)));

  // R6
  read_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_rd) && !$past(bus_swap) && !$past(bus_wr))
      |-> bus_rdata == $past(pend_mask));

  // R7
  release_only_by_store_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(taken_mask) & ~taken_mask & ~($past(bus_wdata) & {NUM_LINES{$past(bus_wr)}})) == '0);
endmodule

bind intr_claim_tracker intr_claim_tracker_chk #(
  .NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_swap(bus_swap), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .irq_pulse(irq_pulse), .pend_mask(pend_mask),
  .taken_mask(taken_mask)
);

// File: tb/intr_claim_tracker_tb.sv
module intr_claim_tracker_tb;
  localparam int N = 28;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic         bus_rd = 1'b0, bus_wr = 1'b0, bus_swap = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         bus_rvalid;
  logic [N-1:0] irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  intr_claim_tracker #(.NUM_LINES(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_swap(bus_swap), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_pulse(irq_pulse)
  );

  // reference model: 0 quiet, 1 waiting, 2 owned
  logic [1:0]   m_st [N];
  logic [N-1:0] m_s1, m_s2, m_pulse, m_rdata;
  logic         m_rvalid;

  function automatic logic [N-1:0] pend_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (m_st[i] == 2'd1);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_st[i] <= 2'd0;
      m_s1 <= '0; m_s2 <= '0; m_pulse <= '0; m_rdata <= '0; m_rvalid <= 1'b0;
    end else begin
      m_s1 <= irq_in;
      m_s2 <= m_s1;
      m_rvalid <= bus_swap || bus_rd;
      if (bus_swap)    m_rdata <= pend_vec() & bus_wdata;
      else if (bus_rd && !bus_wr) m_rdata <= pend_vec();
      else             m_rdata <= '0;
      if (bus_rd && bus_wr && !bus_swap) m_rvalid <= 1'b0;
      for (int i = 0; i < N; i++) begin
        m_pulse[i] <= 1'b0;
        case (m_st[i])
          2'd0: if (m_s2[i]) begin m_st[i] <= 2'd1; m_pulse[i] <= 1'b1; end
          2'd1: if (bus_swap && bus_wdata[i]) m_st[i] <= 2'd2;
          default: if (bus_wr && !bus_swap && bus_wdata[i]) m_st[i] <= 2'd0;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, advance one clock, compare against the model
  task automatic step(logic [N-1:0] irq, logic rd, logic wr, logic sw, logic [N-1:0] wd);
    irq_in = irq; bus_rd = rd; bus_wr = wr; bus_swap = sw; bus_wdata = wd;
    @(negedge clk);
    chk("R3 pulse", irq_pulse, m_pulse);
    chk("R9 rvalid", {{(N-1){1'b0}}, bus_rvalid}, {{(N-1){1'b0}}, m_rvalid});
    chk(sw ? "R4 swap result" : "R6 read result", bus_rdata, m_rdata);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] irq;
    void'($urandom(32'h1c1a_0b5e));
    repeat (4) @(negedge clk);
    chk("R1 pulse", irq_pulse, '0);
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 rvalid", {{(N-1){1'b0}}, bus_rvalid}, '0);
    rst = 1'b0;

    // R2: line 0 rises; pulse appears after the third edge
    step(N'(1), 0, 0, 0, '0);
    chk("R2 early", irq_pulse, '0);
    step(N'(1), 0, 0, 0, '0);
    chk("R2 early", irq_pulse, '0);
    step(N'(1), 0, 0, 0, '0);
    chk("R2 latency", irq_pulse, N'(1));
    step(N'(1), 0, 0, 0, '0);
    chk("R3 one cycle", irq_pulse, '0);
    // R4: claim line 0 (and line 5, which is quiet)
    step(N'(1), 0, 0, 1, N'(33));
    chk("R4 claim", bus_rdata, N'(1));
    // R7: second claim on an owned line loses
    step(N'(1), 0, 0, 1, N'(1));
    chk("R7 swap on owned", bus_rdata, '0);
    step(N'(1), 1, 0, 0, '0);
    chk("R6 owned not listed", bus_rdata, '0);
    // R8: release while input still high re-arms the line
    step(N'(1), 0, 1, 0, N'(1));
    chk("R8 no pulse yet", irq_pulse, '0);
    step(N'(1), 0, 0, 0, '0);
    chk("R8 re-arm pulse", irq_pulse, N'(1));
    // R5: claim, drop input, release, then read shows nothing
    step('0, 0, 0, 1, N'(1));
    step('0, 0, 1, 0, N'(1));
    repeat (3) step('0, 0, 0, 0, '0);
    step('0, 1, 0, 0, '0);
    chk("R5 released", bus_rdata, '0);
    // R10: line 1 pulses then drops; stays waiting
    step(N'(2), 0, 0, 0, '0);
    step(N'(2), 0, 0, 0, '0);
    step('0, 0, 0, 0, '0);
    step('0, 1, 0, 0, '0);
    chk("R10 stays waiting", bus_rdata, N'(2));
    // R7: store on a waiting line is ignored
    step('0, 0, 1, 0, N'(2));
    step('0, 1, 0, 0, '0);
    chk("R7 store ignored", bus_rdata, N'(2));
    // R9: swap and store together: swap acts
    step('0, 0, 1, 1, N'(2));
    chk("R9 swap wins", bus_rdata, N'(2));
    // R4: swap on the very edge line 2 turns waiting
    step(N'(4), 0, 0, 0, '0);
    step(N'(4), 0, 0, 0, '0);
    step(N'(4), 0, 0, 1, N'(4));
    chk("R4 same-edge pulse", irq_pulse, N'(4));
    chk("R4 same-edge claim", bus_rdata, '0);
    step(N'(4), 1, 0, 0, '0);
    chk("R4 still waiting", bus_rdata & N'(4), N'(4));

    // random phase
    irq = '0;
    for (int k = 0; k < 4000; k++) begin
      int c;
      irq ^= N'($urandom & $urandom & $urandom);
      c = int'($urandom % 8);
      step(irq, c < 2 || c == 5, c == 3 || c == 4 || c == 5, c == 2 || c == 4,
           N'($urandom | $urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule